// File: doc/BRIEF.md
# Prioritized Interrupt Request Resolver

This block sits in front of a processor core. It gathers a set of maskable interrupt requests and one non-maskable request. It decides which of them the core should take next, and presents that choice as a pending flag with a small source code.

The maskable sources follow a fixed ranking. Software may lift any single maskable source above all the others, but only while maskable interrupts are globally masked. The external request line passes through a synchronizer. It is then read either as an active-low level or as a falling edge that is remembered until that source is acknowledged.

The block keeps the two mask bits itself. The global maskable mask is I and the non-maskable block is X. The core drives simple strobes to set, clear or restore them. When the core takes a request it pulses an acknowledge. That acknowledge masks further maskable requests and, for the non-maskable source, sets X as well.

Top module: `irq_resolver`

## Requirements
- R1: After reset `irq_pend` is 0, `i_mask` is 1, `x_mask` is 1 and the promoted source is code 0.
- R2: Source codes run 0 to NUM_SRC-1 from highest to lowest fixed rank. Code 0 is the external line, 1 the periodic tick, 2 to 4 captures one to three, 5 to 8 compares one to four, 9 the shared capture-four/compare-five channel, 10 counter overflow, 11 accumulator overflow, 12 accumulator edge, 13 SPI done and 14 the serial port. `periph_req[k]` drives code k+1. With no promotion in effect, the lowest asserted code wins.
- R3: A write on `prom_sel` with `prom_we` makes that code outrank every other maskable source, the external line included. A value of NUM_SRC or above is ignored.
- R4: A promotion write made while `i_mask` is 0 is ignored.
- R5: While `i_mask` is 1, maskable requests raise no `irq_pend` but stay asserted. Once `i_mask` clears, they are granted.
- R6: `i_mask` is set by an acknowledge, loaded from `rti_i_val` on `rti_stb`, set by `mask_set` and cleared by `mask_clr`. When several arrive together, they take effect in that order of precedence.
- R7: The non-maskable request (`nmi_n` low) has code NUM_SRC (15 by default) and outranks every maskable source. It is blocked while `x_mask` is 1.
- R8: `x_clr` clears `x_mask`. On `rti_stb`, `x_mask` becomes `x_mask & rti_x_val`. No strobe can raise `x_mask` once it is 0.
- R9: Acknowledging the non-maskable code sets both `x_mask` and `i_mask`.
- R10: With `edge_mode` 0 the external line requests while it is low. A low pulse that ends before `i_mask` clears leaves nothing pending.
- R11: With `edge_mode` 1 a falling edge on the external line is latched. The latch survives masking and is cleared when code 0 is acknowledged.
- R12: `irq_pend` and `irq_vec` are registered. An `ack` in a cycle with `irq_pend` high drops `irq_pend` in the following cycle, and `irq_vec` is held unchanged across the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_irq_n | input | 1 | External request line, active low, asynchronous |
| periph_req | input | NUM_SRC-1 | On-chip maskable requests; bit k drives code k+1 |
| nmi_n | input | 1 | Non-maskable request, active-low level, asynchronous |
| edge_mode | input | 1 | 0: level sensing of external line, 1: falling-edge sensing |
| prom_we | input | 1 | Promotion write strobe |
| prom_sel | input | VEC_W | Code to promote |
| mask_set | input | 1 | Strobe setting I |
| mask_clr | input | 1 | Strobe clearing I |
| rti_stb | input | 1 | Return strobe restoring I and X |
| rti_i_val | input | 1 | Value restored into I |
| rti_x_val | input | 1 | Value restored into X (can only clear) |
| x_clr | input | 1 | Strobe clearing X |
| ack | input | 1 | Core accepts the pending request |
| irq_pend | output | 1 | A granted request is pending |
| irq_vec | output | VEC_W | Code of the winning source |
| i_mask | output | 1 | Maskable interrupt mask I |
| x_mask | output | 1 | Non-maskable block X |

## Verification
The bench builds the block with NUM_SRC of 15 and SYNC_STAGES of 2. With these values every 4-bit code is in use: the non-maskable code is all ones, and the promotion value 15 is the single out-of-range value that must be dropped. The two synchronizer stages put several cycles between a pin change and a grant. This lets the bench show that a short level pulse is lost while a short falling edge is remembered across a masked period.

// File: rtl/irq_pkg.sv
package irq_pkg;
   // operation applied to the maskable-interrupt mask in one cycle
   typedef enum logic [1:0] {
      MOP_KEEP  = 2'd0,
      MOP_SET   = 2'd1,
      MOP_CLEAR = 2'd2,
      MOP_LOAD  = 2'd3
   } mop_e;

   function automatic int code_bits(input int n_src);
      return $clog2(n_src + 1);
   endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 0 || STAGES > 4) begin : g_bad_stages
      $error("irq_sync: STAGES must be 0..4");
   end

   if (STAGES == 0) begin : g_pass
      logic unused_pass;
      assign unused_pass = clk ^ rst_n;
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sr <= {STAGES{RST_VAL}};
         end else begin
            sr[0] <= d;
            for (int k = 1; k < STAGES; k++) sr[k] <= sr[k-1];
         end
      end
      assign q = sr[STAGES-1];
   end
endmodule

// File: rtl/irq_pin_cond.sv
module irq_pin_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic edge_mode,
   input  logic clr,
   output logic req
);
   logic pin_s;
   logic pin_d;
   logic fall;
   logic flag;

   irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_n),
      .q    (pin_s)
   );

   assign fall = pin_d & ~pin_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_d <= 1'b1;
         flag  <= 1'b0;
      end else begin
         pin_d <= pin_s;
         if (!edge_mode)  flag <= 1'b0;
         else if (fall)   flag <= 1'b1;
         else if (clr)    flag <= 1'b0;
      end
   end

   assign req = edge_mode ? flag : ~pin_s;

   // R11: a latched edge survives until acknowledged or the mode is left
   a_r11_edge_held: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr && edge_mode) |=> (flag || !edge_mode));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int NUM_SRC = 15,
   parameter int VEC_W   = 4
) (
   input  logic [NUM_SRC-1:0] req,
   input  logic [VEC_W-1:0]   prom,
   input  logic               nmi,
   output logic               valid,
   output logic [VEC_W-1:0]   vec
);
   localparam logic [VEC_W-1:0] NMI_CODE = VEC_W'(NUM_SRC);

   logic [NUM_SRC:0]   seen;
   logic [NUM_SRC-1:0] first;
   logic [VEC_W-1:0]   fixed_code;
   logic               prom_hit;

   assign seen[0] = 1'b0;
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_rank
      assign first[g]  = req[g] & ~seen[g];
      assign seen[g+1] = seen[g] | req[g];
   end

   always_comb begin
      fixed_code = '0;
      for (int k = 0; k < NUM_SRC; k++) begin
         if (first[k]) fixed_code = fixed_code | VEC_W'(k);
      end
   end

   assign prom_hit = req[prom];
   assign valid    = nmi | seen[NUM_SRC];
   assign vec      = nmi ? NMI_CODE : (prom_hit ? prom : fixed_code);

   // R2: the single first-ranked grant is one-hot
   always_comb begin
      a_r2_one_first: assert ($onehot0(first));
   end
endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl
   import irq_pkg::*;
#(
   parameter int NUM_SRC = 15,
   parameter int VEC_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_fire,
   input  logic             ack_nmi,
   input  logic             mask_set,
   input  logic             mask_clr,
   input  logic             rti_stb,
   input  logic             rti_i_val,
   input  logic             rti_x_val,
   input  logic             x_clr,
   input  logic             prom_we,
   input  logic [VEC_W-1:0] prom_sel,
   output logic             i_mask,
   output logic             x_mask,
   output logic [VEC_W-1:0] prom
);
   mop_e iop;
   logic prom_ok;

   always_comb begin
      if (ack_fire)      iop = MOP_SET;
      else if (rti_stb)  iop = MOP_LOAD;
      else if (mask_set) iop = MOP_SET;
      else if (mask_clr) iop = MOP_CLEAR;
      else               iop = MOP_KEEP;
   end

   assign prom_ok = prom_we && i_mask && (int'(prom_sel) < NUM_SRC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         i_mask <= 1'b1;
         x_mask <= 1'b1;
         prom   <= '0;
      end else begin
         unique case (iop)
            MOP_SET:   i_mask <= 1'b1;
            MOP_CLEAR: i_mask <= 1'b0;
            MOP_LOAD:  i_mask <= rti_i_val;
            default:   i_mask <= i_mask;
         endcase
         if (ack_nmi)      x_mask <= 1'b1;
         else if (rti_stb) x_mask <= x_mask & rti_x_val;
         else if (x_clr)   x_mask <= 1'b0;
         if (prom_ok) prom <= prom_sel;
      end
   end

   // R8: once cleared, X is only raised by a non-maskable acknowledge
   a_r8_x_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!x_mask && !ack_nmi) |=> !x_mask);
   // R4: promotion frozen while maskable interrupts are enabled
   a_r4_prom_locked: assert property (@(posedge clk) disable iff (!rst_n)
      !i_mask |=> $stable(prom));
   // R9: non-maskable acknowledge raises both masks
   a_r9_nmi_masks: assert property (@(posedge clk) disable iff (!rst_n)
      ack_nmi |=> (x_mask && i_mask));
   // R6: any acknowledge leaves I set
   a_r6_ack_sets_i: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire |=> i_mask);
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
   parameter int NUM_SRC     = 15,
   parameter int VEC_W       = $clog2(NUM_SRC + 1),
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ext_irq_n,
   input  logic [NUM_SRC-2:0] periph_req,
   input  logic               nmi_n,
   input  logic               edge_mode,
   input  logic               prom_we,
   input  logic [VEC_W-1:0]   prom_sel,
   input  logic               mask_set,
   input  logic               mask_clr,
   input  logic               rti_stb,
   input  logic               rti_i_val,
   input  logic               rti_x_val,
   input  logic               x_clr,
   input  logic               ack,
   output logic               irq_pend,
   output logic [VEC_W-1:0]   irq_vec,
   output logic               i_mask,
   output logic               x_mask
);
   localparam int               CODE_W   = irq_pkg::code_bits(NUM_SRC);
   localparam logic [VEC_W-1:0] NMI_CODE = VEC_W'(NUM_SRC);

   if (NUM_SRC < 2) begin : g_bad_src
      $error("irq_resolver: NUM_SRC must be at least 2");
   end
   if (VEC_W < CODE_W) begin : g_bad_vec
      $error("irq_resolver: VEC_W too narrow for NUM_SRC+1 codes");
   end

   logic               ext_req;
   logic               nmi_s;
   logic               nmi_act;
   logic [NUM_SRC-1:0] mreq;
   logic [NUM_SRC-1:0] eff_req;
   logic [VEC_W-1:0]   prom;
   logic               pick_valid;
   logic [VEC_W-1:0]   pick_vec;
   logic               ack_fire;
   logic               ack_nmi;
   logic               ext_clr;

   assign ack_fire = ack & irq_pend;
   assign ack_nmi  = ack_fire & (irq_vec == NMI_CODE);
   assign ext_clr  = ack_fire & (irq_vec == '0);

   irq_pin_cond #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_n    (ext_irq_n),
      .edge_mode(edge_mode),
      .clr      (ext_clr),
      .req      (ext_req)
   );

   irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_nmi_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (nmi_n),
      .q    (nmi_s)
   );

   irq_mask_ctl #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .ack_fire (ack_fire),
      .ack_nmi  (ack_nmi),
      .mask_set (mask_set),
      .mask_clr (mask_clr),
      .rti_stb  (rti_stb),
      .rti_i_val(rti_i_val),
      .rti_x_val(rti_x_val),
      .x_clr    (x_clr),
      .prom_we  (prom_we),
      .prom_sel (prom_sel),
      .i_mask   (i_mask),
      .x_mask   (x_mask),
      .prom     (prom)
   );

   assign mreq    = {periph_req, ext_req};
   assign eff_req = i_mask ? '0 : mreq;
   assign nmi_act = ~nmi_s & ~x_mask;

   irq_prio_pick #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_pick (
      .req  (eff_req),
      .prom (prom),
      .nmi  (nmi_act),
      .valid(pick_valid),
      .vec  (pick_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_pend <= 1'b0;
         irq_vec  <= '0;
      end else begin
         irq_pend <= ack_fire ? 1'b0 : pick_valid;
         if (!ack) irq_vec <= pick_vec;
      end
   end

   // R12: code frozen across the acknowledge cycle
   a_r12_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> $stable(irq_vec));
   // R12: accepted request withdrawn next cycle
   a_r12_pend_drop: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire |=> !irq_pend);
   // R5: a maskable grant only follows a cycle with I clear
   a_r5_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend && irq_vec != NMI_CODE) |-> !$past(i_mask));
   // R7: a non-maskable grant only follows a cycle with X clear
   a_r7_nmi_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend && irq_vec == NMI_CODE) |-> !$past(x_mask));
endmodule

// File: tb/sim_irq_resolver.sv
`timescale 1ns/1ps
module sim_irq_resolver;
   localparam int NSRC = 15;
   localparam int VW   = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ext_irq_n = 1'b1;
   logic [NSRC-2:0] periph_req = '0;
   logic            nmi_n = 1'b1;
   logic            edge_mode = 1'b0;
   logic            prom_we = 1'b0;
   logic [VW-1:0]   prom_sel = '0;
   logic            mask_set = 1'b0;
   logic            mask_clr = 1'b0;
   logic            rti_stb = 1'b0;
   logic            rti_i_val = 1'b0;
   logic            rti_x_val = 1'b0;
   logic            x_clr = 1'b0;
   logic            ack = 1'b0;
   logic            irq_pend;
   logic [VW-1:0]   irq_vec;
   logic            i_mask;
   logic            x_mask;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   int exp_q[$];

   always #4 clk = ~clk;

   irq_resolver #(.NUM_SRC(NSRC), .VEC_W(VW), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .periph_req(periph_req),
      .nmi_n(nmi_n), .edge_mode(edge_mode), .prom_we(prom_we), .prom_sel(prom_sel),
      .mask_set(mask_set), .mask_clr(mask_clr), .rti_stb(rti_stb),
      .rti_i_val(rti_i_val), .rti_x_val(rti_x_val), .x_clr(x_clr), .ack(ack),
      .irq_pend(irq_pend), .irq_vec(irq_vec), .i_mask(i_mask), .x_mask(x_mask)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: pops the expected code whenever the core accepts a request
   always @(negedge clk) begin
      if (rst_n && ack && irq_pend) begin
         n_run++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R12 unexpected grant actual=%0d expected=none", irq_vec);
         end else begin
            int e;
            e = exp_q.pop_front();
            if (int'(irq_vec) != e) begin
               n_fail++;
               $display("FAIL R2/R3/R7 granted code actual=%0d expected=%0d", irq_vec, e);
            end
         end
      end
   end

   // driver: queue the expected code, wait for the grant, acknowledge it
   task automatic serve(input int exp_v);
      int t;
      exp_q.push_back(exp_v);
      t = 0;
      while (!irq_pend && t < 40) begin
         tick(1);
         t++;
      end
      if (!irq_pend) begin
         void'(exp_q.pop_back());
         chk("R5 grant never raised", 0, 1);
      end else begin
         ack = 1'b1;
         tick(1);
         ack = 1'b0;
         chk("R12 pend drops after ack", int'(irq_pend), 0);
      end
   endtask

   task automatic pulse_clr();
      mask_clr = 1'b1; tick(1); mask_clr = 1'b0;
   endtask

   task automatic pulse_set();
      mask_set = 1'b1; tick(1); mask_set = 1'b0;
   endtask

   task automatic write_prom(input int v);
      prom_sel = VW'(v); prom_we = 1'b1; tick(1); prom_we = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 100000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk("R1 pend", int'(irq_pend), 0);
      chk("R1 i_mask", int'(i_mask), 1);
      chk("R1 x_mask", int'(x_mask), 1);

      // R2/R5 fixed ranking, masked requests stay pending
      periph_req[4] = 1'b1; periph_req[8] = 1'b1;
      tick(6);
      chk("R5 masked no pend", int'(irq_pend), 0);
      pulse_clr();
      serve(5);
      chk("R6 ack sets i_mask", int'(i_mask), 1);
      tick(4);
      chk("R5 code 9 held while masked", int'(irq_pend), 0);
      periph_req[4] = 1'b0;
      pulse_clr();
      serve(9);
      periph_req[8] = 1'b0;

      // R3 promotion of code 12 over code 3
      write_prom(12);
      periph_req[2] = 1'b1; periph_req[11] = 1'b1;
      pulse_clr();
      serve(12);
      periph_req[2] = 1'b0; periph_req[11] = 1'b0;

      // R4 write while unmasked is ignored
      pulse_clr();
      write_prom(14);
      periph_req[11] = 1'b1; periph_req[13] = 1'b1;
      serve(12);
      // R3 out-of-range value ignored (I is set here)
      write_prom(15);
      pulse_clr();
      serve(12);
      periph_req[11] = 1'b0; periph_req[13] = 1'b0;

      // R10 level mode, promoted source outranks the external line
      edge_mode = 1'b0;
      ext_irq_n = 1'b0;
      periph_req[11] = 1'b1;
      pulse_clr();
      serve(12);
      periph_req[11] = 1'b0;
      pulse_clr();
      serve(0);
      ext_irq_n = 1'b1;
      tick(4);
      ext_irq_n = 1'b0; tick(3); ext_irq_n = 1'b1;
      tick(6);
      pulse_clr();
      tick(6);
      chk("R10 short low pulse forgotten", int'(irq_pend), 0);
      pulse_set();

      // R11 edge mode latches a short pulse across masking
      edge_mode = 1'b1;
      tick(2);
      ext_irq_n = 1'b0; tick(3); ext_irq_n = 1'b1;
      tick(6);
      chk("R11 latched edge masked", int'(irq_pend), 0);
      pulse_clr();
      serve(0);
      pulse_clr();
      tick(6);
      chk("R11 latch cleared by ack", int'(irq_pend), 0);
      pulse_set();
      edge_mode = 1'b0;

      // R7/R9 non-maskable source
      periph_req[1] = 1'b1;
      nmi_n = 1'b0;
      tick(6);
      chk("R7 blocked by x_mask", int'(irq_pend), 0);
      x_clr = 1'b1; tick(1); x_clr = 1'b0;
      chk("R8 x_clr clears", int'(x_mask), 0);
      serve(15);
      chk("R9 x_mask set by ack", int'(x_mask), 1);
      chk("R9 i_mask set by ack", int'(i_mask), 1);
      nmi_n = 1'b1;
      tick(4);
      rti_i_val = 1'b0; rti_x_val = 1'b0; rti_stb = 1'b1; tick(1); rti_stb = 1'b0;
      chk("R8 rti restores x", int'(x_mask), 0);
      chk("R6 rti restores i", int'(i_mask), 0);
      serve(2);
      rti_i_val = 1'b1; rti_x_val = 1'b1; rti_stb = 1'b1; tick(1); rti_stb = 1'b0;
      chk("R8 x cannot be set", int'(x_mask), 0);
      chk("R6 rti loads i", int'(i_mask), 1);
      periph_req[1] = 1'b0;

      // R6 set beats clear in the same cycle
      pulse_clr();
      mask_set = 1'b1; mask_clr = 1'b1; tick(1); mask_set = 1'b0; mask_clr = 1'b0;
      chk("R6 set over clear", int'(i_mask), 1);

      tick(4);
      chk("R12 scoreboard drained", exp_q.size(), 0);
      finish_run();
   end
endmodule